// File: doc/BRIEF.md
# Timed Autorange Range Counter

This block selects the measurement range of a digital voltmeter. The active range is held as a small code in an up/down counter. Up-range and down-range requests from the overload and underrange comparators move the code by one step. The counter accepts a step only in a clock cycle that carries a slow pacing tick, so a request held for a long time still produces one step per tick. The count stops at the lowest and the highest range. It moves only while the meter is set to measure voltage.

The code is decoded into one-hot range-select lines through a decoder with an active-low enable. The enable is low in automatic mode. It is also low in remote mode while no remote range line is pulled low, so the meter then autoranges under remote control. When a remote line is pulled low, the decoder is disabled and that line's range is selected directly. The counter is loaded with the matching code so that autoranging later resumes from that range. The range codes are 0 for 2 V, 1 for 20 V, 2 for 200 V and 3 for 1000 V. A synchronous reset selects the highest range.

Top module: `autorange_ctrl`

## Requirements
- R1: The range code changes through autoranging only at the clock edge that ends a cycle with `tick` high, and by at most one step per tick, however long a command is held.
- R2: On a tick, `dn_cmd` alone decrements the code and `up_cmd` alone increments it. Both or neither high leaves the code unchanged.
- R3: At code 0 (2 V), a tick with `dn_cmd` high leaves the code at 0.
- R4: At code N_RANGES-1 (code 3, 1000 V, by default), a tick with `up_cmd` high leaves the code at N_RANGES-1.
- R5: While `volt_mode` is low, ticks and commands do not change the code.
- R6: `range_code` carries the counter value in its low $clog2(N_RANGES) bits. The remaining upper bits, including the fourth decoder input, are 0.
- R7: `dec_en_n` is low when `auto_mode` is 1. It is also low when `auto_mode` is 0 and every `remote_n` bit is 1. While `dec_en_n` is low, `range_sel` has exactly bit `range_code` set.
- R8: In remote mode (`auto_mode` 0) with any `remote_n[i]` low, `dec_en_n` is high and `range_sel` is one-hot at the lowest such i in the same cycle. At the next edge the code becomes i, and ticks do not step it.
- R9: In automatic mode, the `remote_n` lines have no effect on the code, the enable or the selects.
- R10: A cycle with `rst` high sets the code to N_RANGES-1 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle pacing pulse from the prescaler |
| up_cmd | input | 1 | Up-range request, active high |
| dn_cmd | input | 1 | Down-range request, active high |
| volt_mode | input | 1 | 1 while the meter measures voltage |
| auto_mode | input | 1 | 1 automatic, 0 remote |
| remote_n | input | N_RANGES | Remote range lines, bit i low requests range i |
| range_code | output | CODE_W | Decoder input code, low bits first |
| dec_en_n | output | 1 | Decoder enable, active low |
| range_sel | output | N_RANGES | One-hot range selects |

## Verification
The bench builds the block with its defaults: four ranges and a four-bit decoder code. With four ranges, a few ticks drive the counter from the reset ceiling down to the floor and back up again. The same width also lets two remote lines be pulled low at once, which exercises the lowest-index priority. A zero fourth bit in every expected code confirms that the upper decoder input stays low across all vectors.

// File: rtl/autorange_pkg.sv
package autorange_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/arc_remote_sel.sv
module arc_remote_sel #(
  parameter int N_RANGES = 4,
  parameter int CNT_W    = 2
) (
  input  logic                auto_mode,
  input  logic [N_RANGES-1:0] remote_n,
  output logic                remote_act,
  output logic [CNT_W-1:0]    remote_idx,
  output logic [N_RANGES-1:0] remote_oh
);
  // lowest-index active (low) line wins
  function automatic logic [CNT_W-1:0] lowest_low(input logic [N_RANGES-1:0] lines);
    logic [CNT_W-1:0] idx;
    idx = '0;
    for (int i = N_RANGES - 1; i >= 0; i--) begin
      if (!lines[i]) idx = CNT_W'(i);
    end
    return idx;
  endfunction

  logic any_low;

  assign any_low    = !(&remote_n);
  assign remote_act = !auto_mode && any_low;
  assign remote_idx = lowest_low(remote_n);

  generate
    for (genvar g = 0; g < N_RANGES; g++) begin : g_oh
      assign remote_oh[g] = remote_act && (remote_idx == CNT_W'(g));
    end
  endgenerate
endmodule

// File: rtl/arc_step_ctrl.sv
module arc_step_ctrl
  import autorange_pkg::*;
#(
  parameter int N_RANGES = 4,
  parameter int CNT_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_ok,
  input  logic             up_cmd,
  input  logic             dn_cmd,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_idx,
  output logic [CNT_W-1:0] count,
  output logic             at_floor,
  output logic             at_ceil,
  output logic             step_up_ev,
  output logic             step_dn_ev
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(N_RANGES - 1);

  function automatic step_e pick_dir(input logic up, input logic dn);
    if (up && !dn) return STEP_UP;
    if (dn && !up) return STEP_DN;
    return STEP_HOLD;
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input step_e dir);
    case (dir)
      STEP_UP: return (cur == TOP) ? cur : cur + 1'b1;
      STEP_DN: return (cur == '0)  ? cur : cur - 1'b1;
      default: return cur;
    endcase
  endfunction

  step_e dir;

  assign dir        = step_ok ? pick_dir(up_cmd, dn_cmd) : STEP_HOLD;
  assign at_floor   = (count == '0);
  assign at_ceil    = (count == TOP);
  assign step_up_ev = (dir == STEP_UP) && !at_ceil;
  assign step_dn_ev = (dir == STEP_DN) && !at_floor;

  always_ff @(posedge clk) begin
    if (rst)          count <= TOP;
    else if (load_en) count <= load_idx;
    else              count <= next_count(count, dir);
  end
endmodule

// File: rtl/arc_range_dec.sv
module arc_range_dec #(
  parameter int N_RANGES = 4,
  parameter int CNT_W    = 2
) (
  input  logic                en_n,
  input  logic [CNT_W-1:0]    code,
  input  logic [N_RANGES-1:0] direct_oh,
  output logic [N_RANGES-1:0] sel
);
  generate
    for (genvar g = 0; g < N_RANGES; g++) begin : g_dec
      assign sel[g] = en_n ? direct_oh[g] : (code == CNT_W'(g));
    end
  endgenerate
endmodule

// File: rtl/autorange_ctrl.sv
module autorange_ctrl #(
  parameter int N_RANGES = 4,
  parameter int CODE_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                up_cmd,
  input  logic                dn_cmd,
  input  logic                volt_mode,
  input  logic                auto_mode,
  input  logic [N_RANGES-1:0] remote_n,
  output logic [CODE_W-1:0]   range_code,
  output logic                dec_en_n,
  output logic [N_RANGES-1:0] range_sel
);
  localparam int CNT_W = (N_RANGES > 1) ? $clog2(N_RANGES) : 1;

  logic                remote_act;
  logic [CNT_W-1:0]    remote_idx;
  logic [N_RANGES-1:0] remote_oh;
  logic [CNT_W-1:0]    count;
  logic                step_ok;
  logic                load_ev;
  logic                at_floor;
  logic                at_ceil;
  logic                step_up_ev;
  logic                step_dn_ev;

  arc_remote_sel #(.N_RANGES(N_RANGES), .CNT_W(CNT_W)) u_remote (
    .auto_mode  (auto_mode),
    .remote_n   (remote_n),
    .remote_act (remote_act),
    .remote_idx (remote_idx),
    .remote_oh  (remote_oh)
  );

  assign load_ev  = remote_act;
  assign step_ok  = tick && volt_mode && !remote_act;
  assign dec_en_n = !(auto_mode || !remote_act);

  arc_step_ctrl #(.N_RANGES(N_RANGES), .CNT_W(CNT_W)) u_step (
    .clk        (clk),
    .rst        (rst),
    .step_ok    (step_ok),
    .up_cmd     (up_cmd),
    .dn_cmd     (dn_cmd),
    .load_en    (load_ev),
    .load_idx   (remote_idx),
    .count      (count),
    .at_floor   (at_floor),
    .at_ceil    (at_ceil),
    .step_up_ev (step_up_ev),
    .step_dn_ev (step_dn_ev)
  );

  assign range_code = CODE_W'(count);

  arc_range_dec #(.N_RANGES(N_RANGES), .CNT_W(CNT_W)) u_dec (
    .en_n      (dec_en_n),
    .code      (count),
    .direct_oh (remote_oh),
    .sel       (range_sel)
  );
endmodule

// File: rtl/arc_checker.sv
module arc_checker #(
  parameter int N_RANGES = 4,
  parameter int CODE_W   = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                tick,
  input logic                up_cmd,
  input logic                dn_cmd,
  input logic                volt_mode,
  input logic                auto_mode,
  input logic [N_RANGES-1:0] remote_n,
  input logic [CODE_W-1:0]   range_code,
  input logic                dec_en_n,
  input logic [N_RANGES-1:0] range_sel,
  input logic                load_ev,
  input logic                at_floor,
  input logic                at_ceil
);
  localparam int CNT_W = (N_RANGES > 1) ? $clog2(N_RANGES) : 1;
  localparam logic [CODE_W-1:0] TOP = CODE_W'(N_RANGES - 1);

  logic seen_edge = 1'b0;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  AST_STEP_ON_TICK_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load_ev) |=> (range_code == $past(range_code))); // R1

  AST_FLOOR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tick && volt_mode && !load_ev && dn_cmd && !up_cmd && at_floor)
      |=> (range_code == '0)); // R3

  AST_CEIL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tick && volt_mode && !load_ev && up_cmd && !dn_cmd && at_ceil)
      |=> (range_code == TOP)); // R4

  AST_VOLT_GATE: assert property (@(posedge clk) disable iff (rst)
    (!volt_mode && !load_ev) |=> (range_code == $past(range_code))); // R5

  AST_UPPER_CODE_LOW: assert property (@(posedge clk) disable iff (rst)
    (range_code >> CNT_W) == '0); // R6

  AST_AUTO_ENABLES: assert property (@(posedge clk) disable iff (rst)
    auto_mode |-> !dec_en_n); // R7

  AST_SEL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !dec_en_n |-> ($countones(range_sel) == 1 && range_sel[range_code[CNT_W-1:0]])); // R7

  AST_SEL_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(range_sel)); // R8

  AST_REMOTE_DISABLES: assert property (@(posedge clk) disable iff (rst)
    (!auto_mode && !(&remote_n)) |-> dec_en_n); // R8

  AST_RESET_TOP: assert property (@(posedge clk)
    (seen_edge && $past(rst)) |-> (range_code == TOP)); // R10
endmodule

bind autorange_ctrl arc_checker #(.N_RANGES(N_RANGES), .CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .up_cmd     (up_cmd),
  .dn_cmd     (dn_cmd),
  .volt_mode  (volt_mode),
  .auto_mode  (auto_mode),
  .remote_n   (remote_n),
  .range_code (range_code),
  .dec_en_n   (dec_en_n),
  .range_sel  (range_sel),
  .load_ev    (load_ev),
  .at_floor   (at_floor),
  .at_ceil    (at_ceil)
);

// File: tb/tb_autorange_ctrl.sv
`timescale 1ns/1ps
module tb_autorange_ctrl;
  localparam int N = 4;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b0;
  logic          up_cmd = 1'b0;
  logic          dn_cmd = 1'b0;
  logic          volt_mode = 1'b1;
  logic          auto_mode = 1'b1;
  logic [N-1:0]  remote_n = '1;
  logic [CW-1:0] range_code;
  logic          dec_en_n;
  logic [N-1:0]  range_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  autorange_ctrl #(.N_RANGES(N), .CODE_W(CW)) dut (
    .clk(clk), .rst(rst), .tick(tick), .up_cmd(up_cmd), .dn_cmd(dn_cmd),
    .volt_mode(volt_mode), .auto_mode(auto_mode), .remote_n(remote_n),
    .range_code(range_code), .dec_en_n(dec_en_n), .range_sel(range_sel)
  );

  // fields: auto volt remote_n[4] up dn tick | code[4] en_n sel[4]
  localparam int NV = 17;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1,1'b1,4'hF,1'b0,1'b1,1'b1, 4'd2,1'b0,4'b0100}, // R2 down
    {1'b1,1'b1,4'hF,1'b0,1'b1,1'b0, 4'd2,1'b0,4'b0100}, // R1 held, no tick
    {1'b1,1'b1,4'hF,1'b0,1'b1,1'b1, 4'd1,1'b0,4'b0010}, // R2
    {1'b1,1'b1,4'hF,1'b0,1'b1,1'b1, 4'd0,1'b0,4'b0001}, // R2
    {1'b1,1'b1,4'hF,1'b0,1'b1,1'b1, 4'd0,1'b0,4'b0001}, // R3 floor
    {1'b1,1'b1,4'hF,1'b1,1'b1,1'b1, 4'd0,1'b0,4'b0001}, // R2 both hold
    {1'b1,1'b1,4'hF,1'b1,1'b0,1'b1, 4'd1,1'b0,4'b0010}, // R2 up
    {1'b1,1'b0,4'hF,1'b1,1'b0,1'b1, 4'd1,1'b0,4'b0010}, // R5 gated
    {1'b1,1'b1,4'hF,1'b1,1'b0,1'b1, 4'd2,1'b0,4'b0100}, // R2
    {1'b1,1'b1,4'hF,1'b1,1'b0,1'b1, 4'd3,1'b0,4'b1000}, // R2
    {1'b1,1'b1,4'hF,1'b1,1'b0,1'b1, 4'd3,1'b0,4'b1000}, // R4 ceiling
    {1'b0,1'b1,4'hF,1'b0,1'b1,1'b1, 4'd2,1'b0,4'b0100}, // R7 remote autorange
    {1'b0,1'b1,4'hD,1'b0,1'b0,1'b0, 4'd1,1'b1,4'b0010}, // R8 load line 1
    {1'b0,1'b1,4'hD,1'b0,1'b1,1'b1, 4'd1,1'b1,4'b0010}, // R8 tick ignored
    {1'b0,1'b1,4'hC,1'b0,1'b0,1'b0, 4'd0,1'b1,4'b0001}, // R8 priority
    {1'b0,1'b1,4'hF,1'b1,1'b0,1'b1, 4'd1,1'b0,4'b0010}, // R7 resume
    {1'b1,1'b1,4'hE,1'b1,1'b0,1'b1, 4'd2,1'b0,4'b0100}  // R9 lines ignored
  };

  task automatic check(input string req, input logic [CW-1:0] ec,
                       input logic ee, input logic [N-1:0] es);
    checks++;
    if (range_code !== ec || dec_en_n !== ee || range_sel !== es) begin
      fails++;
      $display("FAIL %s: code=%0d en_n=%b sel=%b expected code=%0d en_n=%b sel=%b",
               req, range_code, dec_en_n, range_sel, ec, ee, es);
    end
  endtask

  initial begin
    #(5.0 * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R10 reset top", 4'd3, 1'b0, 4'b1000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      auto_mode = VEC[i][17];
      volt_mode = VEC[i][16];
      remote_n  = VEC[i][15:12];
      up_cmd    = VEC[i][11];
      dn_cmd    = VEC[i][10];
      tick      = VEC[i][9];
      @(posedge clk);
      #1 tick = 1'b0;
      @(negedge clk);
      check($sformatf("R1/R2/R6 vector %0d", i), VEC[i][8:5], VEC[i][4], VEC[i][3:0]);
    end

    // R1: long-held down request, one tick gives one step only
    @(negedge clk);
    auto_mode = 1'b1; volt_mode = 1'b1; remote_n = '1; up_cmd = 1'b0; dn_cmd = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 held without tick", 4'd2, 1'b0, 4'b0100);
    tick = 1'b1;
    @(posedge clk);
    #1 tick = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 single step per tick", 4'd1, 1'b0, 4'b0010);

    // R9: remote lines in auto mode do not change the selects combinationally
    remote_n = 4'b0111; dn_cmd = 1'b0;
    #0.5;
    check("R9 auto ignores remote", 4'd1, 1'b0, 4'b0010);

    // R8: remote select appears in the same cycle, before the load edge
    @(negedge clk);
    remote_n = 4'b1011; auto_mode = 1'b0;
    #0.5;
    checks++;
    if (dec_en_n !== 1'b1 || range_sel !== 4'b0100) begin
      fails++;
      $display("FAIL R8 same-cycle select: en_n=%b sel=%b expected en_n=1 sel=0100",
               dec_en_n, range_sel);
    end

    // R10: reset mid-run with a tick and command overrides
    @(negedge clk);
    auto_mode = 1'b1; remote_n = '1; dn_cmd = 1'b1; tick = 1'b1; rst = 1'b1;
    @(posedge clk);
    #1 tick = 1'b0;
    @(negedge clk);
    rst = 1'b0; dn_cmd = 1'b0;
    check("R10 mid-run reset", 4'd3, 1'b0, 4'b1000);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule